// File: doc/BRIEF.md
# T1 Superframe Alignment Synchronizer

This block takes a serial T1 bit stream, one bit per cycle in which a valid strobe is high. It finds where frame alignment sits and reports it. A T1 frame is 193 bits long and its first bit is a framing bit. Twelve frames make a superframe. The framing bits of odd frames carry the terminal pattern and the framing bits of even frames carry the signalling pattern. The block only aligns to the stream. It produces no signalling and does not touch the payload.

Alignment is reached in two stages. The block first hunts for the terminal framing bit, which alternates at 386-bit spacing. Once that is found it clears the loss-of-frame flag and searches the even-frame framing bits for the signalling sequence that marks frame 12. After that it reports a frame number and a bit position. In sync, each of the two patterns is checked against its own expected value and feeds its own error window. Loss on either pattern drops both alignments together, and the hunt starts again.

Top module: `t1sf_sync`

## Requirements
- R1: A synchronous active-high reset sets `frame_lost`=1, `mframe_lost`=1 and `frame_num`=0.
- R2: While hunting, the bit under test is the candidate position, and every 386 valid bits it is compared with the value it had at the previous check. Terminal lock is declared when the value has alternated on 3 consecutive compares, which takes 4 samples. At that point `frame_lost` falls on the cycle after the locking bit and `bit_pos` reads 0. A compare that finds no change moves the candidate one bit later and restarts the count.
- R3: After terminal lock, `mframe_lost` stays 1 and `frame_num` stays 0 while the signalling framing bits are collected. The expected values for frames 2,4,6,8,10,12 are 0,0,1,1,1,0. When the six most recent samples match that sequence, the newest sample is taken as frame 12 and `frame_num` becomes 12.
- R4: Once multiframe lock is reached, `mframe_lost` falls after the first framing-bit check that is correct. Until then it stays 1.
- R5: `bit_pos` (0..192) is the position of the last accepted bit within its frame, where 0 is the framing bit. `frame_num` (1..12) is that bit's frame while in multiframe sync and 0 otherwise. Terminal framing bits of frames 1,3,5,7,9,11 are expected to be 1,0,1,0,1,0.
- R6: A cycle with `bit_vld` low changes no output and no state.
- R7: `win_sel` 0, 1 and 2/3 select a window N of 4, 5 and 6 checks. An error on a pattern that has another error among that same pattern's preceding N-1 checks is a loss. The terminal and signalling patterns have separate histories. One isolated error is not a loss.
- R8: A loss on either pattern sets `frame_lost` and `mframe_lost` after the offending bit and forces `frame_num` to 0. The terminal hunt then restarts at the current candidate position.
- R9: `frame_lost` high always implies `mframe_lost` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Line bit strobe |
| bit_in | input | 1 | Line bit, sampled when `bit_vld` is high |
| win_sel | input | 2 | Error window select (0:4, 1:5, 2/3:6) |
| frame_lost | output | 1 | Terminal (frame) alignment lost |
| mframe_lost | output | 1 | Multiframe alignment lost |
| frame_num | output | 4 | Frame of last bit, 1..12, 0 when not multiframe-aligned |
| bit_pos | output | POS_W | Position of last bit within its frame |

## Verification
The bench builds the block with the default parameters: 193-bit frames, a confirmation count of 3 and a 6-deep error history. With these values the slip path is reached by starting the stream three bits off the framing position, which forces three rejected candidates before lock. The full superframe search is covered, including the case where only five of the six signalling samples have been seen. Window settings 4 and 6 are both used: terminal errors spaced four checks apart are not a loss, errors three checks apart are, and signalling errors five checks apart are a loss only under the 6-check window.

// File: rtl/t1sf_pkg.sv
`timescale 1ns/1ps
package t1sf_pkg;

    localparam int SF_FRAMES = 12;
    localparam int SEQ_LEN   = 6;

    // terminal bits of frames 1..11, frame 1 at MSB
    localparam logic [SEQ_LEN-1:0] FT_SEQ = 6'b101010;
    // signalling bits of frames 2..12, frame 2 at MSB (oldest)
    localparam logic [SEQ_LEN-1:0] FS_SEQ = 6'b001110;

    typedef enum logic [1:0] {
        ST_HUNT_T = 2'd0,
        ST_HUNT_M = 2'd1,
        ST_SYNC   = 2'd2
    } sync_state_e;

    typedef struct packed {
        logic chk;
        logic err;
    } fcheck_t;

    function automatic logic ft_expect(logic [3:0] f);
        int i;
        i = (int'(f) - 1) / 2;
        if (i < 0) i = 0;
        if (i > SEQ_LEN-1) i = SEQ_LEN-1;
        return FT_SEQ[SEQ_LEN-1-i];
    endfunction

    function automatic logic fs_expect(logic [3:0] f);
        int i;
        i = int'(f) / 2 - 1;
        if (i < 0) i = 0;
        if (i > SEQ_LEN-1) i = SEQ_LEN-1;
        return FS_SEQ[SEQ_LEN-1-i];
    endfunction

    function automatic logic [3:0] frame_after(logic [3:0] f);
        return (f == 4'(SF_FRAMES)) ? 4'd1 : f + 4'd1;
    endfunction

    function automatic int win_len(logic [1:0] sel);
        case (sel)
            2'd0:    return 4;
            2'd1:    return 5;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/t1sf_pos_ctr.sv
`timescale 1ns/1ps
module t1sf_pos_ctr #(
    parameter int FRAME_BITS = 193,
    parameter int DP_W       = $clog2(2*FRAME_BITS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            slip,
    output logic [DP_W-1:0] dpos,
    output logic            at_ft,
    output logic            at_fs
);
    localparam logic [DP_W-1:0] FS_POS = DP_W'(FRAME_BITS);
    localparam logic [DP_W-1:0] LAST   = DP_W'(2*FRAME_BITS-1);

    always_ff @(posedge clk) begin
        if (rst)
            dpos <= '0;
        else if (adv && !slip)
            dpos <= (dpos == LAST) ? '0 : dpos + 1'b1;
    end

    assign at_ft = (dpos == '0);
    assign at_fs = (dpos == FS_POS);

    // R5
    dpos_range_chk: assert property (@(posedge clk) disable iff (rst)
        dpos <= LAST);

    // R2
    slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && slip) |=> at_ft);

endmodule

// File: rtl/t1sf_err_win.sv
`timescale 1ns/1ps
module t1sf_err_win
    import t1sf_pkg::*;
#(
    parameter int MAX_WIN = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       chk,
    input  logic       err,
    input  logic [1:0] win_sel,
    output logic       loss
);
    localparam int HW = MAX_WIN - 1;

    logic [HW-1:0] hist;
    logic [HW-1:0] mask;

    always_comb begin
        for (int i = 0; i < HW; i++)
            mask[i] = (i < win_len(win_sel) - 1);
    end

    assign loss = chk && err && (|(hist & mask));

    always_ff @(posedge clk) begin
        if (rst || clr)
            hist <= '0;
        else if (chk)
            hist <= {hist[HW-2:0], err};
    end

endmodule

// File: rtl/t1sf_mf_find.sv
`timescale 1ns/1ps
module t1sf_mf_find
    import t1sf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic take,
    input  logic fs_bit,
    output logic found
);
    localparam int CW = $clog2(SEQ_LEN);

    logic [SEQ_LEN-2:0] sr;
    logic [CW-1:0]      cnt;
    logic               full;

    assign full  = (cnt == CW'(SEQ_LEN-1));
    assign found = take && full && ({sr, fs_bit} == FS_SEQ);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr  <= '0;
            cnt <= '0;
        end else if (take) begin
            sr <= {sr[SEQ_LEN-3:0], fs_bit};
            if (!full) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/t1sf_sync.sv
`timescale 1ns/1ps
module t1sf_sync
    import t1sf_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int CONFIRM    = 3,
    parameter int MAX_WIN    = 6,
    parameter int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic [1:0]       win_sel,
    output logic             frame_lost,
    output logic             mframe_lost,
    output logic [3:0]       frame_num,
    output logic [POS_W-1:0] bit_pos
);
    localparam int DP_W = $clog2(2*FRAME_BITS);
    localparam int MC_W = $clog2(CONFIRM+1);
    localparam logic [DP_W-1:0] FS_POS     = DP_W'(FRAME_BITS);
    localparam logic [3:0]      LAST_FRAME = 4'(SF_FRAMES);

    sync_state_e      state, nxt;
    logic [MC_W-1:0]  match_cnt;
    logic             last_ft;
    logic [3:0]       fcur;
    logic             lof_q, lomf_q;
    logic [POS_W-1:0] pos_q;

    logic [DP_W-1:0]  dpos;
    logic             at_ft, at_fs;
    logic             hunt_chk, slip, hunt_lock;
    logic [3:0]       frame_in;
    logic [DP_W-1:0]  fpos_full;
    logic             mf_found;
    fcheck_t          pchk [2];
    logic             wclr [2];
    logic             wloss[2];
    logic             any_loss;

    t1sf_pos_ctr #(.FRAME_BITS(FRAME_BITS), .DP_W(DP_W)) u_pos (
        .clk  (clk),
        .rst  (rst),
        .adv  (bit_vld),
        .slip (slip),
        .dpos (dpos),
        .at_ft(at_ft),
        .at_fs(at_fs)
    );

    // ---- terminal hunt ----
    assign hunt_chk  = bit_vld && at_ft && (state == ST_HUNT_T);
    assign slip      = hunt_chk && (match_cnt != '0) && (bit_in == last_ft);
    assign hunt_lock = hunt_chk && (match_cnt == MC_W'(CONFIRM)) && (bit_in != last_ft);

    // ---- frame tracking ----
    always_comb begin
        if (state != ST_SYNC)
            frame_in = 4'd0;
        else if (at_ft || at_fs)
            frame_in = frame_after(fcur);
        else
            frame_in = fcur;
    end

    assign fpos_full = (dpos >= FS_POS) ? dpos - FS_POS : dpos;

    // ---- pattern checks: index 0 terminal, index 1 signalling ----
    always_comb begin
        pchk[0].chk = bit_vld && at_ft && (state != ST_HUNT_T);
        pchk[0].err = (state == ST_SYNC) ? (bit_in != ft_expect(frame_in))
                                         : (bit_in == last_ft);
        pchk[1].chk = bit_vld && at_fs && (state == ST_SYNC);
        pchk[1].err = (bit_in != fs_expect(frame_in));
        wclr[0]     = (state == ST_HUNT_T);
        wclr[1]     = (state != ST_SYNC);
    end

    for (genvar g = 0; g < 2; g++) begin : g_win
        t1sf_err_win #(.MAX_WIN(MAX_WIN)) u_win (
            .clk    (clk),
            .rst    (rst),
            .clr    (wclr[g]),
            .chk    (pchk[g].chk),
            .err    (pchk[g].err),
            .win_sel(win_sel),
            .loss   (wloss[g])
        );
    end

    assign any_loss = wloss[0] || wloss[1];

    // ---- multiframe search ----
    t1sf_mf_find u_mf (
        .clk   (clk),
        .rst   (rst),
        .clr   (state != ST_HUNT_M),
        .take  (bit_vld && at_fs && (state == ST_HUNT_M)),
        .fs_bit(bit_in),
        .found (mf_found)
    );

    // ---- state machine ----
    always_comb begin
        nxt = state;
        case (state)
            ST_HUNT_T: if (hunt_lock) nxt = ST_HUNT_M;
            ST_HUNT_M: begin
                if (any_loss)      nxt = ST_HUNT_T;
                else if (mf_found) nxt = ST_SYNC;
            end
            ST_SYNC:   if (any_loss) nxt = ST_HUNT_T;
            default:   nxt = ST_HUNT_T;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT_T;
            match_cnt <= '0;
            last_ft   <= 1'b0;
            fcur      <= 4'd0;
            lof_q     <= 1'b1;
            lomf_q    <= 1'b1;
            pos_q     <= '0;
        end else if (bit_vld) begin
            state <= nxt;
            pos_q <= POS_W'(fpos_full);
            lof_q <= (nxt == ST_HUNT_T);

            if (hunt_chk) begin
                if (match_cnt == '0) begin
                    last_ft   <= bit_in;
                    match_cnt <= MC_W'(1);
                end else if (bit_in != last_ft) begin
                    last_ft   <= bit_in;
                    match_cnt <= hunt_lock ? '0 : match_cnt + 1'b1;
                end else begin
                    match_cnt <= '0;
                end
            end else if (pchk[0].chk) begin
                last_ft <= ~last_ft;
            end

            if (nxt != ST_SYNC)
                fcur <= 4'd0;
            else if (state == ST_HUNT_M)
                fcur <= LAST_FRAME;
            else
                fcur <= frame_in;

            if (nxt != ST_SYNC || state == ST_HUNT_M)
                lomf_q <= 1'b1;
            else if ((pchk[0].chk && !pchk[0].err) || (pchk[1].chk && !pchk[1].err))
                lomf_q <= 1'b0;
        end
    end

    assign frame_lost  = lof_q;
    assign mframe_lost = lomf_q;
    assign frame_num   = fcur;
    assign bit_pos     = pos_q;

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (frame_lost && mframe_lost && frame_num == 4'd0));

    // R9
    lof_lomf_chk: assert property (@(posedge clk) disable iff (rst)
        frame_lost |-> mframe_lost);

    // R5
    fnum_range_chk: assert property (@(posedge clk) disable iff (rst)
        frame_num <= LAST_FRAME);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> ($stable(frame_lost) && $stable(mframe_lost)
                      && $stable(frame_num) && $stable(bit_pos)));

    // R8
    loss_both_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_lost) |-> (mframe_lost && frame_num == 4'd0));

    // R4
    mf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mframe_lost) |-> (!frame_lost && frame_num != 4'd0));

endmodule

// File: tb/t1sf_sync_bench.sv
`timescale 1ns/1ps
module t1sf_sync_bench;

    localparam int FB  = 193;
    localparam int OFF = 3;
    localparam int LAST_N = 22790;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_vld;
    logic       bit_in;
    logic [1:0] win_sel;
    logic       frame_lost, mframe_lost;
    logic [3:0] frame_num;
    logic [7:0] bit_pos;

    always #2.5 clk = ~clk;

    t1sf_sync u_t1sf_sync (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .win_sel    (win_sel),
        .frame_lost (frame_lost),
        .mframe_lost(mframe_lost),
        .frame_num  (frame_num),
        .bit_pos    (bit_pos)
    );

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        int    idx;
        int    lof;
        int    lomf;
        int    fnum;
        int    bpos;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic expect_at(int idx, int lof, int lomf, int fnum, int bpos, string tag);
        exp_t e;
        e.idx = idx; e.lof = lof; e.lomf = lomf; e.fnum = fnum; e.bpos = bpos; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // ---- stream model ----
    int ft_b[6] = '{1, 0, 1, 0, 1, 0};
    int fs_b[6] = '{0, 0, 1, 1, 1, 0};

    function automatic bit flip_here(int fi);
        return fi == 36 || fi == 44 || fi == 60 || fi == 66 || fi == 101 || fi == 111;
    endfunction

    function automatic logic stream_bit(int k);
        int fi, f, b;
        if (k < 0 || (k % FB) != 0) return 1'b0;
        fi = k / FB;
        f  = fi % 12 + 1;
        b  = (f % 2 == 1) ? ft_b[(f-1)/2] : fs_b[f/2-1];
        if (flip_here(fi)) b = 1 - b;
        return logic'(b);
    endfunction

    function automatic int n_of(int frame_idx);
        return frame_idx * FB + OFF;
    endfunction

    // ---- monitor ----
    logic took = 1'b0;
    logic was_rst = 1'b1;
    int   mon_cnt = 0;

    always @(posedge clk) begin
        took    <= bit_vld && !rst;
        was_rst <= rst;
    end

    always @(negedge clk) begin
        if (was_rst) begin
            mon_cnt = 0;
        end else if (took) begin
            if (exp_q.size() > 0 && exp_q[0].idx == mon_cnt) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.lof >= 0)
                    check(frame_lost == e.lof, {e.tag, " frame_lost"}, int'(frame_lost), e.lof);
                if (e.lomf >= 0)
                    check(mframe_lost == e.lomf, {e.tag, " mframe_lost"}, int'(mframe_lost), e.lomf);
                if (e.fnum >= 0)
                    check(int'(frame_num) == e.fnum, {e.tag, " frame_num"}, int'(frame_num), e.fnum);
                if (e.bpos >= 0)
                    check(int'(bit_pos) == e.bpos, {e.tag, " bit_pos"}, int'(bit_pos), e.bpos);
                check(!(frame_lost && !mframe_lost), "R9 lof implies lomf",
                      int'(mframe_lost), 1);
            end
            mon_cnt++;
        end
    end

    // ---- watchdog ----
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // ---- driver ----
    initial begin
        logic       s_lof, s_lomf;
        logic [3:0] s_fn;
        logic [7:0] s_bp;

        rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0; win_sel = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(frame_lost == 1'b1, "R1 frame_lost", int'(frame_lost), 1);
        check(mframe_lost == 1'b1, "R1 mframe_lost", int'(mframe_lost), 1);
        check(frame_num == 4'd0, "R1 frame_num", int'(frame_num), 0);

        // R2 hunt with three rejected candidates, lock on frame-index 12
        expect_at(n_of(12) - 1, 1, 1, 0, -1, "R2 before lock");
        expect_at(n_of(12),     0, 1, 0, 0,  "R2 terminal lock");
        expect_at(n_of(12) + 10, 0, 1, 0, 10, "R5 pos in hunt_m");
        // R3 multiframe search
        expect_at(n_of(23) - 1, 0, 1, 0, -1, "R3 still searching");
        expect_at(n_of(23),     0, 1, 12, 0, "R3 frame 12 found");
        // R4 clear on first correct check
        expect_at(n_of(24) - 1, 0, 1, 12, 192, "R4 lomf held");
        expect_at(n_of(24),     0, 0, 1, 0, "R4 lomf cleared");
        expect_at(n_of(25) + 7, 0, 0, 2, 7, "R5 frame and pos");
        // R7 errors four terminal checks apart, window 4: no loss
        expect_at(n_of(44),     0, 0, 9, 0, "R7 spaced errors");
        expect_at(n_of(66) - 1, 0, 0, 6, 192, "R7 before second error");
        // R8 loss on errors three checks apart
        expect_at(n_of(66),     1, 1, 0, -1, "R8 loss both flags");
        expect_at(n_of(74),     0, 1, 0, 0, "R2 relock");
        expect_at(n_of(83),     0, 1, 0, 0, "R3 five samples only");
        expect_at(n_of(95),     0, 1, 12, 0, "R3 resync frame 12");
        expect_at(n_of(96),     0, 0, 1, 0, "R4 lomf cleared again");
        // R7 signalling errors five apart, window 6
        expect_at(n_of(111) - 1, 0, 0, 3, 192, "R7 fs before loss");
        expect_at(n_of(111),     1, 1, 0, -1, "R7 fs window-6 loss");
        expect_at(n_of(118),     0, 1, 0, 0, "R8 hunt restarts");

        for (int n = 0; n <= LAST_N; n++) begin
            int k;
            k = n - OFF;
            @(posedge clk); #1;
            if (k == 97 * FB) win_sel = 2'd2;
            bit_vld = 1'b1;
            bit_in  = stream_bit(k);
            if (n == 3000) begin
                @(posedge clk); #1;
                bit_vld = 1'b0; bit_in = 1'b1;
                @(negedge clk);
                s_lof = frame_lost; s_lomf = mframe_lost; s_fn = frame_num; s_bp = bit_pos;
                for (int j = 0; j < 4; j++) begin
                    @(posedge clk); #1;
                    bit_in = ~bit_in;
                end
                @(negedge clk);
                // R6 idle cycles leave outputs untouched
                check(bit_pos == s_bp, "R6 bit_pos idle", int'(bit_pos), int'(s_bp));
                check(frame_num == s_fn, "R6 frame_num idle", int'(frame_num), int'(s_fn));
                check(frame_lost == s_lof && mframe_lost == s_lomf, "R6 flags idle",
                      int'({frame_lost, mframe_lost}), int'({s_lof, s_lomf}));
            end else if (n % 7 == 6) begin
                @(posedge clk); #1;
                bit_vld = 1'b0;
                bit_in  = ~bit_in;
            end
        end
        @(posedge clk); #1;
        bit_vld = 1'b0;
        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "R2 all expectations reached", exp_q.size(), 0);

        #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset from a locked state
        check(frame_lost == 1'b1 && mframe_lost == 1'b1, "R1 flags after reset",
              int'({frame_lost, mframe_lost}), 3);
        check(frame_num == 4'd0, "R1 frame_num after reset", int'(frame_num), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule